// File: doc/BRIEF.md
# Streaming Vertical-Gradient Edge Filter

This block takes a raster-scanned 8-bit greyscale frame, one pixel per transfer on a valid/ready input stream. It returns a frame of the same size on a valid/ready output stream, where each output pixel is a 3x3 vertical-gradient convolution centred on the matching input pixel. Two line memories keep the two previous input lines. Two column registers and the incoming column form the 3x3 neighbourhood.

Neighbours that fall outside the frame take the value of the nearest edge pixel. The signed weighted sum is clamped into the range 0 to 255. Output pixel (y,x) can only be formed once input pixel (y+1,x+1) is known. For that reason the block's internal scan runs one extra column step per line and one extra line per frame. During these steps no input is taken and the last column and the last line are flushed out. The output stream marks the first pixel of a frame and the last pixel of each line.

Top module: `sobel_stream`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1, and the next accepted pixel is taken as pixel (0,0) of a frame.
- R2: Each output pixel equals (B(x-1) + 2*B(x) + B(x+1)) - (T(x-1) + 2*T(x) + T(x+1)), clamped. B is the line below the output pixel's line and T is the line above it, both in the same column neighbourhood.
- R3: A weighted sum below 0 is output as 0.
- R4: A weighted sum above 255 is output as 255.
- R5: For line 0 the line above is replaced by line 0 itself. For the last line the line below is replaced by the last line itself.
- R6: For column 0 the left neighbour is replaced by column 0 itself. For the last column the right neighbour is replaced by the last column itself.
- R7: Each input frame of W*H pixels yields exactly W*H output pixels in raster order, and no output appears once the frame has been flushed.
- R8: out_sof is 1 exactly on output pixel (0,0), and out_eol is 1 exactly on output pixels with x = W-1.
- R9: While out_valid is 1 and out_ready is 0, out_pix, out_sof and out_eol hold their values, out_valid stays 1 and in_ready is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Block accepts the input pixel this cycle |
| in_pix | input | 8 | Input greyscale pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Downstream accepts the output pixel |
| out_pix | output | 8 | Filtered, clamped pixel |
| out_sof | output | 1 | Marks output pixel (0,0) |
| out_eol | output | 1 | Marks the last pixel of an output line |

## Verification
If a line memory address or a column register is stale, the error shows as wrong pixel values at the image edges, or one line or column later. The pixel-exact compare against a model of the kernel, the edge rule and the clamp catches it within the first affected line. A slip in the scan counters shifts out_eol and out_sof away from their positions and changes the number of output pixels per frame. The framing checks report this at the first wrong line end. A handshake fault under back-pressure shows as a changed or dropped pixel while out_ready is low. The checker flags it in the following cycle, and the bench compare flags it at the pixel concerned.

// File: rtl/sobel_stream.sv
module sobel_stream #(
  parameter int W = 1920,
  parameter int H = 1080
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_pix,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_pix,
  output logic       out_sof,
  output logic       out_eol
);
  localparam int CW = $clog2(W + 1);
  localparam int RW = $clog2(H + 1);
  localparam int AW = $clog2(W);

  logic [CW-1:0] col;
  logic [RW-1:0] row;
  logic [7:0] lb_near [W];
  logic [7:0] lb_far  [W];
  logic [2:0][7:0] prv, pp, cur, lft;
  logic [AW-1:0] idx;
  logic [7:0] m_raw, t_raw, top, bot;
  logic last_col, last_row, need_in, advance, step, emit;
  logic [9:0] wt, wb;
  logic signed [10:0] diff;
  logic [7:0] sat;

  assign last_col = (col == CW'(W));
  assign last_row = (row == RW'(H));
  assign need_in  = !last_col && !last_row;
  assign advance  = !out_valid || out_ready;
  assign in_ready = need_in && advance;
  assign step     = advance && (need_in ? in_valid : 1'b1);
  assign emit     = (row != '0) && (col != '0);

  assign idx   = last_col ? '0 : AW'(col);
  assign m_raw = lb_near[idx];
  assign t_raw = lb_far[idx];
  assign bot   = last_row ? m_raw : in_pix;
  assign top   = (row == RW'(1)) ? m_raw : t_raw;
  assign cur   = last_col ? prv : {top, m_raw, bot};
  assign lft   = (col == CW'(1)) ? prv : pp;

  assign wt = {2'b0, lft[2]} + {1'b0, prv[2], 1'b0} + {2'b0, cur[2]};
  assign wb = {2'b0, lft[0]} + {1'b0, prv[0], 1'b0} + {2'b0, cur[0]};
  assign diff = $signed({1'b0, wb}) - $signed({1'b0, wt});
  assign sat  = diff[10] ? 8'd0 : (diff > 11'sd255) ? 8'd255 : diff[7:0];

  always_ff @(posedge clk) begin
    if (step && need_in) begin
      lb_far[idx]  <= lb_near[idx];
      lb_near[idx] <= in_pix;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      prv <= '0;
      pp  <= '0;
    end else if (step) begin
      pp  <= prv;
      prv <= cur;
      if (last_col) begin
        col <= '0;
        row <= last_row ? '0 : row + RW'(1);
      end else begin
        col <= col + CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
      out_sof   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (step && emit) begin
      out_valid <= 1'b1;
      out_pix   <= sat;
      out_sof   <= (row == RW'(1)) && (col == CW'(1));
      out_eol   <= last_col;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/sobel_stream_chk.sv
module sobel_stream_chk #(
  parameter int W = 1920,
  parameter int H = 1080
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_pix,
  input logic       out_sof,
  input logic       out_eol
);
  int xcnt, ycnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xcnt <= 0;
      ycnt <= 0;
    end else if (out_valid && out_ready) begin
      if (xcnt == W - 1) begin
        xcnt <= 0;
        ycnt <= (ycnt == H - 1) ? 0 : ycnt + 1;
      end else begin
        xcnt <= xcnt + 1;
      end
    end
  end

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix) && $stable(out_sof) && $stable(out_eol)));

  // R9
  stall_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  eol_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_eol == (xcnt == W - 1)));

  // R8
  sof_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> (out_sof == (xcnt == 0 && ycnt == 0)));
endmodule

bind sobel_stream sobel_stream_chk #(.W(W), .H(H)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
);

// File: tb/tb_sobel_stream.sv
module tb_sobel_stream;
  localparam int W = 8;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [7:0] in_pix = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_pix;
  logic out_sof, out_eol;

  int total = 0;
  int fails = 0;
  int img [H][W];
  bit stall_mode = 0;

  always #10 clk = ~clk;

  sobel_stream #(.W(W), .H(H)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
    .out_pix(out_pix), .out_sof(out_sof), .out_eol(out_eol)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(int p, int y, int x);
    case (p)
      0: return 77;
      1: return y * 40;
      2: return (y < 3) ? 255 : 0;
      3: return (y < 3) ? 0 : 255;
      4: return int'($urandom_range(255));
      default: return (x * 37 + y * y * 11) % 256;
    endcase
  endfunction

  function automatic int expv(int y, int x);
    int t, b, l, r, s;
    t = (y == 0) ? 0 : y - 1;
    b = (y == H - 1) ? H - 1 : y + 1;
    l = (x == 0) ? 0 : x - 1;
    r = (x == W - 1) ? W - 1 : x + 1;
    s = img[b][l] + 2 * img[b][x] + img[b][r] - img[t][l] - 2 * img[t][x] - img[t][r];
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic drive();
    for (int k = 0; k < W * H; k++) begin
      if (stall_mode && ($urandom_range(3) == 0)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_pix = 8'(img[k / W][k % W]);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(string req);
    for (int k = 0; k < W * H; k++) begin
      do begin
        @(negedge clk);
        out_ready = stall_mode ? ($urandom_range(2) != 0) : 1'b1;
        #2;
      end while (!(out_valid && out_ready));
      chk(out_pix == 8'(expv(k / W, k % W)), req, $sformatf("pixel (%0d,%0d)", k / W, k % W),
          out_pix, expv(k / W, k % W));
      // R8
      chk(out_sof == (k == 0), "R8", "out_sof", out_sof, k == 0);
      chk(out_eol == (k % W == W - 1), "R8", "out_eol", out_eol, k % W == W - 1);
    end
  endtask

  task automatic run_frame(int p, bit stall, string req);
    int extra;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = pat(p, y, x);
    stall_mode = stall;
    fork
      drive();
      collect(req);
    join
    out_ready = 1'b1;
    extra = 0;
    repeat (3 * W) begin
      @(negedge clk);
      if (out_valid) extra++;
    end
    // R7
    chk(extra == 0, "R7", "outputs after frame", extra, 0);
  endtask

  task automatic test_reset();
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  task automatic test_flat();      run_frame(0, 0, "R2"); endtask
  task automatic test_vramp();     run_frame(1, 0, "R5"); endtask
  task automatic test_clamp_neg(); run_frame(2, 0, "R3"); endtask
  task automatic test_clamp_pos(); run_frame(3, 0, "R4"); endtask
  task automatic test_columns();   run_frame(5, 0, "R6"); endtask
  task automatic test_backpress(); run_frame(4, 1, "R9"); endtask
  task automatic test_stall_cols(); run_frame(5, 1, "R6"); endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    test_reset();
    test_flat();
    test_vramp();
    test_clamp_neg();
    test_clamp_pos();
    test_columns();
    test_backpress();
    test_stall_cols();
    test_backpress();
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end
endmodule